// File: doc/BRIEF.md
# IPv4 Header Rewrite Engine

This block sits in a frame datapath that carries Ethernet frames as 32-bit big-endian words. A start marker flags the first word and an end marker flags the last. For every IPv4 frame it lowers the time-to-live by one and patches the header checksum to match, without ever recomputing the checksum over the whole header. It also verifies the header as the words stream past. Frames with any other EtherType come out exactly as they went in.

Each word leaves a fixed number of cycles after it enters, so the stream keeps its timing. Idle cycles between words are allowed. The last word of each frame carries a one-bit status that a later stage can use to discard frames with a broken header. There is no backpressure: the next stage must accept one word per cycle.

Top module: `ip_hdr_rewrite`

## Requirements
- R1: While reset is asserted, and until the first word has travelled through, `o_valid`, `o_sop`, `o_eop` and `o_err` are all 0.
- R2: Every valid input word appears on the output exactly LATENCY cycles later (2 by default), with the same start and end markers. Word count and framing are kept.
- R3: Words are numbered from 0 at the start marker. A frame is IPv4 when bits 31:16 of word 3 equal 0x0800. A frame with another value there, or one that ends before word 3, passes through bit for bit and never reports an error.
- R4: For an eligible frame, byte 22 of the frame (bits 15:8 of word 5, the time-to-live) leaves the block reduced by one.
- R5: For an eligible frame, bits 31:16 of word 6 (the header checksum) leave the block as old + 0x0100 in one's-complement arithmetic: a 17-bit sum whose carry out is added back into bit 0.
- R6: An IPv4 frame is eligible only if its version nibble (word 3 bits 15:12) is 4, its header-length nibble (word 3 bits 11:8) is at least 5, and its arriving time-to-live is at least 2. A frame that is not eligible has neither field modified and is reported bad.
- R7: The received header is checked over 4×IHL bytes from frame byte 14. The one's-complement sum of its 16-bit halfwords must be 0xFFFF; otherwise the frame is reported bad, and the rewrite of R4/R5 is still applied.
- R8: An IPv4 frame whose end marker comes before word IHL+3 (the word holding the last header bytes) is reported bad.
- R9: `o_err` can be 1 only on a valid word that carries the end marker. Every word other than word 5 and word 6 of an eligible frame leaves the block unmodified.
- R10: Idle cycles between the words of a frame do not change the output data or the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_valid | input | 1 | Input word present this cycle |
| i_sop | input | 1 | Input word is the first of a frame |
| i_eop | input | 1 | Input word is the last of a frame |
| i_data | input | DATA_W | Input word, first frame byte in bits 31:24 |
| o_valid | output | 1 | Output word present this cycle |
| o_sop | output | 1 | Output word is the first of a frame |
| o_eop | output | 1 | Output word is the last of a frame |
| o_data | output | DATA_W | Output word after rewriting |
| o_err | output | 1 | Header rejected; meaningful on the last word only |

## Verification
The assertions assume well-formed framing at the input: `i_sop` and `i_eop` are sampled only when `i_valid` is high, and every frame opens with a start marker before any other word is sent. They also assume that a checksum edit is never requested for the word that lowered the time-to-live, which relies on the two fields lying in different words. The bench drives only complete frames, each with exactly one start and one end marker. It varies the idle gaps between words, so every property is exercised under the framing it assumes.

// File: rtl/ip_rw_pkg.sv
package ip_rw_pkg;

   localparam int unsigned BUS_W     = 32;
   localparam int unsigned HW_W      = 16;
   // word indices counted from the start marker; their order is behaviour
   localparam int unsigned IDX_ETYPE = 3;
   localparam int unsigned IDX_TTL   = 5;
   localparam int unsigned IDX_CKS   = 6;
   localparam int unsigned HDR_BIAS  = 3;
   localparam int unsigned MIN_IHL   = 5;
   localparam int unsigned IP_VER    = 4;

   typedef struct packed {
      logic             valid;
      logic             sop;
      logic             eop;
      logic             err;
      logic [BUS_W-1:0] data;
   } beat_t;

   // one's-complement 16-bit add with end-around carry
   function automatic logic [HW_W-1:0] oc_add(input logic [HW_W-1:0] a,
                                              input logic [HW_W-1:0] b);
      logic [HW_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[HW_W-1:0] + {{(HW_W-1){1'b0}}, s[HW_W]};
   endfunction

endpackage

// File: rtl/ip_rw_parse.sv
module ip_rw_parse
   import ip_rw_pkg::*;
#(
   parameter logic [15:0] ETYPE   = 16'h0800,
   parameter int unsigned MIN_TTL = 2,
   parameter int unsigned IDX_W   = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_valid,
   input  logic             i_sop,
   input  logic [BUS_W-1:0] i_data,
   output logic             o_edit_ttl,
   output logic             o_edit_cks,
   output logic             o_frame_err
);

   localparam logic [IDX_W-1:0] IDX_MAX = '1;
   localparam logic [7:0]       TTL_LO  = 8'(MIN_TTL);
   localparam logic [3:0]       VER4    = 4'(IP_VER);
   localparam logic [3:0]       IHL_LO  = 4'(MIN_IHL);

   logic [IDX_W-1:0] cnt_q, cur, hdr_end;
   logic             ip_q, ttl_q, done_q, rw_q;
   logic [3:0]       ver_q, ihl_q;
   logic [HW_W-1:0]  acc_q;

   logic             ip_b, ttl_b, done_b, rw_b;
   logic [3:0]       ver_b, ihl_b;
   logic [HW_W-1:0]  acc_b;

   logic             ip_n, ttl_n, done_n, rw_n;
   logic [3:0]       ver_n, ihl_n;
   logic [HW_W-1:0]  acc_n;
   logic [HW_W-1:0]  hw_hi, hw_lo;

   always_comb begin
      cur    = i_sop ? '0 : cnt_q;
      ip_b   = !i_sop && ip_q;
      ttl_b  = !i_sop && ttl_q;
      done_b = !i_sop && done_q;
      rw_b   = !i_sop && rw_q;
      ver_b  = i_sop ? '0 : ver_q;
      ihl_b  = i_sop ? '0 : ihl_q;
      acc_b  = i_sop ? '0 : acc_q;
      hw_hi  = i_data[BUS_W-1:HW_W];
      hw_lo  = i_data[HW_W-1:0];

      ip_n   = ip_b;
      ttl_n  = ttl_b;
      done_n = done_b;
      rw_n   = rw_b;
      ver_n  = ver_b;
      ihl_n  = ihl_b;
      acc_n  = acc_b;
      hdr_end    = IDX_W'(ihl_b) + IDX_W'(HDR_BIAS);
      o_edit_ttl = 1'b0;
      o_edit_cks = 1'b0;

      if (cur == IDX_W'(IDX_ETYPE)) begin
         ip_n  = (hw_hi == ETYPE);
         ver_n = hw_lo[15:12];
         ihl_n = hw_lo[11:8];
         acc_n = hw_lo;
      end else if (ip_b && !done_b && cur > IDX_W'(IDX_ETYPE)) begin
         if (cur <= hdr_end) acc_n = oc_add(acc_n, hw_hi);
         if (cur <  hdr_end) acc_n = oc_add(acc_n, hw_lo);
         if (cur == hdr_end) done_n = 1'b1;
      end

      if (cur == IDX_W'(IDX_TTL) && ip_b) begin
         ttl_n      = (hw_lo[15:8] >= TTL_LO);
         rw_n       = ttl_n && (ver_b == VER4) && (ihl_b >= IHL_LO);
         o_edit_ttl = i_valid && rw_n;
      end

      if (cur == IDX_W'(IDX_CKS) && rw_b) o_edit_cks = i_valid;

      o_frame_err = ip_n && ((ver_n != VER4) || (ihl_n < IHL_LO) || !ttl_n ||
                             !done_n || (acc_n != '1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         ip_q   <= 1'b0;
         ttl_q  <= 1'b0;
         done_q <= 1'b0;
         rw_q   <= 1'b0;
         ver_q  <= '0;
         ihl_q  <= '0;
         acc_q  <= '0;
      end else if (i_valid) begin
         cnt_q  <= (cur == IDX_MAX) ? cur : cur + IDX_W'(1);
         ip_q   <= ip_n;
         ttl_q  <= ttl_n;
         done_q <= done_n;
         rw_q   <= rw_n;
         ver_q  <= ver_n;
         ihl_q  <= ihl_n;
         acc_q  <= acc_n;
      end
   end

   AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid && i_sop) |=> (cnt_q == IDX_W'(1))) else $error("index restart"); // R3

   AST_CKS_AFTER_VER: assert property (@(posedge clk) disable iff (!rst_n)
      o_edit_cks |-> (ver_q == VER4 && ttl_q)) else $error("checksum edit without valid header"); // R6

endmodule

// File: rtl/ip_rw_edit.sv
module ip_rw_edit
   import ip_rw_pkg::*;
#(
   parameter int unsigned MIN_TTL = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_valid,
   input  logic             i_sop,
   input  logic             i_eop,
   input  logic [BUS_W-1:0] i_data,
   input  logic             i_edit_ttl,
   input  logic             i_edit_cks,
   input  logic             i_frame_err,
   output beat_t            o_beat
);

   localparam logic [7:0]      TTL_LO = 8'(MIN_TTL);
   localparam logic [HW_W-1:0] CKS_INC = 16'h0100;

   logic [HW_W-1:0]  new_hc;
   logic [BUS_W-1:0] word;

   always_comb begin
      new_hc = oc_add(i_data[BUS_W-1:HW_W], CKS_INC);
      word   = i_data;
      if (i_edit_ttl) word[15:8] = i_data[15:8] - 8'd1;
      if (i_edit_cks) word[BUS_W-1:HW_W] = new_hc;
      o_beat.valid = i_valid;
      o_beat.sop   = i_valid && i_sop;
      o_beat.eop   = i_valid && i_eop;
      o_beat.err   = i_valid && i_eop && i_frame_err;
      o_beat.data  = i_valid ? word : '0;
   end

   AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(i_edit_ttl && i_edit_cks)) else $error("two edits in one word"); // R5

   AST_HC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      i_edit_cks |-> (new_hc != '0)) else $error("checksum folded to zero"); // R5

   AST_TTL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      i_edit_ttl |-> (i_data[15:8] >= TTL_LO)) else $error("low ttl decremented"); // R6

endmodule

// File: rtl/ip_rw_pipe.sv
module ip_rw_pipe
   import ip_rw_pkg::*;
#(
   parameter int unsigned DEPTH = 2
)(
   input  logic  clk,
   input  logic  rst_n,
   input  beat_t i_beat,
   output beat_t o_beat
);

   generate
      if (DEPTH == 1) begin : g_single
         beat_t r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= i_beat;
         end
         assign o_beat = r;
      end else begin : g_chain
         beat_t r [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < DEPTH; k++) r[k] <= '0;
            end else begin
               r[0] <= i_beat;
               for (int k = 1; k < DEPTH; k++) r[k] <= r[k-1];
            end
         end
         assign o_beat = r[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/ip_hdr_rewrite.sv
module ip_hdr_rewrite
   import ip_rw_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LATENCY   = 2,
   parameter logic [15:0] ETHERTYPE = 16'h0800,
   parameter int unsigned MIN_TTL   = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              i_valid,
   input  logic              i_sop,
   input  logic              i_eop,
   input  logic [DATA_W-1:0] i_data,
   output logic              o_valid,
   output logic              o_sop,
   output logic              o_eop,
   output logic [DATA_W-1:0] o_data,
   output logic              o_err
);

   // last header word index is 15 + HDR_BIAS; one spare code for saturation
   localparam int unsigned IDX_W = $clog2(16 + HDR_BIAS + 1);

   generate
      if (DATA_W != BUS_W) begin : g_bad_width
         initial $error("DATA_W must equal %0d", BUS_W);
      end
      if (LATENCY < 1) begin : g_bad_lat
         initial $error("LATENCY must be at least 1");
      end
      if (MIN_TTL < 1 || MIN_TTL > 255) begin : g_bad_ttl
         initial $error("MIN_TTL out of range");
      end
   endgenerate

   logic  edit_ttl, edit_cks, frame_err;
   beat_t beat_in, beat_out;

   ip_rw_parse #(
      .ETYPE   (ETHERTYPE),
      .MIN_TTL (MIN_TTL),
      .IDX_W   (IDX_W)
   ) u_parse (
      .clk         (clk),
      .rst_n       (rst_n),
      .i_valid     (i_valid),
      .i_sop       (i_sop),
      .i_data      (i_data),
      .o_edit_ttl  (edit_ttl),
      .o_edit_cks  (edit_cks),
      .o_frame_err (frame_err)
   );

   ip_rw_edit #(
      .MIN_TTL (MIN_TTL)
   ) u_edit (
      .clk         (clk),
      .rst_n       (rst_n),
      .i_valid     (i_valid),
      .i_sop       (i_sop),
      .i_eop       (i_eop),
      .i_data      (i_data),
      .i_edit_ttl  (edit_ttl),
      .i_edit_cks  (edit_cks),
      .i_frame_err (frame_err),
      .o_beat      (beat_in)
   );

   ip_rw_pipe #(
      .DEPTH (LATENCY)
   ) u_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .i_beat (beat_in),
      .o_beat (beat_out)
   );

   assign o_valid = beat_out.valid;
   assign o_sop   = beat_out.sop;
   assign o_eop   = beat_out.eop;
   assign o_err   = beat_out.err;
   assign o_data  = beat_out.data;

   AST_ERR_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      o_err |-> (o_valid && o_eop)) else $error("status off the last word"); // R9

   AST_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (o_sop || o_eop) |-> o_valid) else $error("marker without valid"); // R2

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> !(o_valid || o_err)) else $error("output during reset"); // R1

endmodule

// File: tb/tb_ip_hdr_rewrite.sv
module tb_ip_hdr_rewrite;

   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        i_valid, i_sop, i_eop;
   logic [31:0] i_data;
   logic        o_valid, o_sop, o_eop, o_err;
   logic [31:0] o_data;

   always #2 clk = ~clk;

   ip_hdr_rewrite #(.LATENCY(LAT)) dut (
      .clk(clk), .rst_n(rst_n),
      .i_valid(i_valid), .i_sop(i_sop), .i_eop(i_eop), .i_data(i_data),
      .o_valid(o_valid), .o_sop(o_sop), .o_eop(o_eop), .o_data(o_data), .o_err(o_err)
   );

   int n_run = 0, n_bad = 0, cyc = 0;
   bit finished = 0;
   logic [7:0]  fb [0:127];
   logic [7:0]  eb [0:127];
   logic [31:0] got [0:63];
   int nw, gcnt, stray, in_sop_cyc, out_sop_cyc;
   logic got_err;
   bit   got_eop;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (o_valid) begin
         if (o_sop) begin gcnt = 0; out_sop_cyc = cyc; end
         if (gcnt < 64) got[gcnt] = o_data;
         gcnt++;
         if (o_err && !o_eop) stray++;
         if (o_eop) begin got_err = o_err; got_eop = 1; end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ocs(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

   function automatic logic [15:0] hsum(input int nbytes);
      logic [15:0] s = 16'h0000;
      for (int k = 0; k < nbytes; k += 2) s = ocs(s, {fb[14+k], fb[15+k]});
      return s;
   endfunction

   task automatic seal();
      int hl;
      hl = (fb[14][3:0] >= 5) ? int'(fb[14][3:0]) : 5;
      fb[24] = 8'h00; fb[25] = 8'h00;
      {fb[24], fb[25]} = ~hsum(4 * hl);
   endtask

   task automatic mk(input logic [15:0] et, input logic [3:0] ver, input logic [3:0] ihl,
                     input logic [7:0] ttl, input logic [15:0] id, input int words);
      for (int i = 0; i < 128; i++) fb[i] = 8'(i * 37 + 11);
      {fb[12], fb[13]} = et;
      fb[14] = {ver, ihl};
      fb[15] = 8'h00;
      {fb[16], fb[17]} = 16'(words * 4 - 14);
      {fb[18], fb[19]} = id;
      fb[20] = 8'h40; fb[21] = 8'h00;
      fb[22] = ttl;   fb[23] = 8'h11;
      nw = words;
      seal();
   endtask

   task automatic run(input int gap, input string dreq, input string ereq);
      bit ip, elig, sum_ok, exp_err;
      logic [3:0] ver, ihl;
      logic [7:0] ttl;
      int mis;
      logic [31:0] ew;
      for (int i = 0; i < 128; i++) eb[i] = fb[i];
      ip  = (nw >= 4) && ({fb[12], fb[13]} == 16'h0800);
      ver = fb[14][7:4];
      ihl = fb[14][3:0];
      ttl = fb[22];
      elig = ip && (nw >= 6) && ver == 4'd4 && ihl >= 4'd5 && ttl >= 8'd2;
      if (elig) begin
         eb[22] = ttl - 8'd1;
         if (nw >= 7) {eb[24], eb[25]} = ocs({fb[24], fb[25]}, 16'h0100);
      end
      sum_ok  = (ihl >= 4'd5) && (nw >= int'(ihl) + 4) && (hsum(4 * int'(ihl)) == 16'hFFFF);
      exp_err = ip && !(ver == 4'd4 && ihl >= 4'd5 && nw >= 6 && ttl >= 8'd2 && sum_ok);

      gcnt = 0; got_eop = 0; got_err = 0; stray = 0;
      for (int w = 0; w < nw; w++) begin
         @(negedge clk);
         i_valid = 1'b1;
         i_sop   = (w == 0);
         i_eop   = (w == nw - 1);
         i_data  = {fb[4*w], fb[4*w+1], fb[4*w+2], fb[4*w+3]};
         if (w == 0) in_sop_cyc = cyc;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            i_valid = 1'b0; i_sop = 1'b0; i_eop = 1'b0;
         end
      end
      @(negedge clk);
      i_valid = 1'b0; i_sop = 1'b0; i_eop = 1'b0;
      for (int i = 0; i < LAT + 3; i++) @(negedge clk);

      chk(gcnt == nw && got_eop, "R2", "word count", gcnt, nw);
      chk(out_sop_cyc - in_sop_cyc == LAT, "R2", "latency", out_sop_cyc - in_sop_cyc, LAT);
      mis = -1;
      ew  = 32'h0;
      for (int w = 0; w < nw && w < 64; w++) begin
         if (mis < 0 && got[w] !== {eb[4*w], eb[4*w+1], eb[4*w+2], eb[4*w+3]}) begin
            mis = w;
            ew  = {eb[4*w], eb[4*w+1], eb[4*w+2], eb[4*w+3]};
         end
      end
      chk(mis < 0, dreq, $sformatf("data word %0d", mis), (mis < 0) ? 0 : got[mis], ew);
      chk(got_err === exp_err, ereq, "status", got_err, exp_err);
      chk(stray == 0, "R9", "status off last word", stray, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] ets [6];
      logic [15:0] tgts [6];
      logic [15:0] s0;
      ets  = '{16'h86DD, 16'h0806, 16'h0801, 16'h0000, 16'h8100, 16'h0008};
      tgts = '{16'hFEFF, 16'hFF00, 16'hFFFE, 16'h0001, 16'h00FF, 16'h8000};
      i_valid = 0; i_sop = 0; i_eop = 0; i_data = '0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(!o_valid && !o_err && !o_sop && !o_eop, "R1", "outputs in reset", o_valid, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!o_valid && !o_err, "R1", "outputs after reset", o_valid, 0);

      // R4 R5 R6: full time-to-live sweep, gap pattern per R10
      for (int t = 0; t < 256; t++) begin
         mk(16'h0800, 4'd4, 4'd5, 8'(t), 16'(t * 91 + 7), 12);
         run(t % 3, "R4", "R6");
      end
      // R6 R7: header length sweep with options
      for (int h = 0; h < 16; h++) begin
         mk(16'h0800, 4'd4, 4'(h), 8'd64, 16'(h * 1234), 22);
         run(h % 2, "R6", "R7");
      end
      // R6: version sweep
      for (int v = 0; v < 16; v++) begin
         mk(16'h0800, 4'(v), 4'd5, 8'd100, 16'h1357, 10);
         run(0, "R6", "R6");
      end
      // R3: other EtherTypes pass untouched
      foreach (ets[k]) begin
         mk(ets[k], 4'd4, 4'd5, 8'd64, 16'(k), 10);
         run(k % 2, "R3", "R3");
      end
      // R7: corrupted header bytes
      for (int b = 14; b < 34; b++) begin
         mk(16'h0800, 4'd4, 4'd5, 8'd33, 16'hBEEF, 11);
         fb[b] = fb[b] ^ 8'h01;
         run(0, "R7", "R7");
      end
      // R8: short frames
      for (int n = 1; n <= 10; n++) begin
         mk(16'h0800, 4'd4, 4'd5, 8'd64, 16'h0F0F, n);
         run(n % 2, "R8", "R8");
      end
      // R8: header ends exactly at or just beyond the frame end
      for (int h = 6; h < 16; h++) begin
         mk(16'h0800, 4'd4, 4'(h), 8'd9, 16'h2222, h + 3);
         run(0, "R8", "R8");
         mk(16'h0800, 4'd4, 4'(h), 8'd9, 16'h2222, h + 4);
         run(0, "R8", "R8");
      end
      // R5: checksum values near the fold boundary
      foreach (tgts[k]) begin
         mk(16'h0800, 4'd4, 4'd5, 8'd200, 16'h0000, 9);
         fb[24] = 8'h00; fb[25] = 8'h00;
         s0 = hsum(20);
         {fb[18], fb[19]} = ocs(~tgts[k], ~s0);
         seal();
         run(k % 3, "R5", "R7");
      end
      // R10: long idle gaps
      for (int g = 4; g < 8; g++) begin
         mk(16'h0800, 4'd4, 4'd5, 8'(g * 17), 16'(g), 8);
         run(g, "R10", "R10");
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule